// File: doc/BRIEF.md
# MIDI Serial Note Receiver

This block is a receive-only serial port for a MIDI line, clocked at 4 MHz. At that clock one bit time at 31,250 bit/s is 128 cycles. The asynchronous line first passes through a two-flop synchronizer. The block then waits for the line to go low, which marks a start bit. It takes one sample of each of the eight data bits near the centre of the bit, and the data arrive least significant bit first. The stop bit is not sampled and no framing check is made. After the last data bit the receiver waits until the line is high again, and only then looks for the next start bit. Frames can therefore follow each other with no gap or with any amount of idle time.

A message stage follows the byte receiver. It keeps track of where each byte sits within a three-byte note message. Any byte with the top bit set is a status byte and restarts the message. The note number from the second byte is held until the velocity arrives as the third byte. At that point a note-on shows the 7-bit note with a valid flag. A note-off for the same note clears both. The block is meant to drive a small display of the note that is currently sounding.

Top module: `midi_note_rx`

## Requirements
- R1: After reset, `note_o` is 0 and `note_vld_o` is 0.
- R2: The receiver arms only when it has seen the line high. A frame starts when the synchronized line is low while the receiver is armed. Each frame is re-armed separately, so any idle time between frames is accepted.
- R3: Data bit k (k = 0..7) is sampled once, 192 + 128·k cycles after start detection, and shifted in least significant bit first. Frames sent at bit periods of 127, 128 and 129 cycles are all received correctly.
- R4: Frames that follow each other with no idle time between them are all received.
- R5: The stop bit is not checked. A byte whose stop bit is low is still delivered.
- R6: After the eighth data bit the receiver stays disarmed until the line returns high. A line held low after a frame therefore produces no extra byte.
- R7: A status byte with upper nibble 0x9, followed by a note byte and a nonzero velocity byte, sets `note_o` to the note byte's bits [6:0] and sets `note_vld_o` to 1.
- R8: `note_o` and `note_vld_o` change only when a velocity byte (the third byte of a message) is received. The status byte and the note byte leave them unchanged.
- R9: A note-off clears `note_o` to 0 and `note_vld_o` to 0, but only when its note number equals the note shown. A note-off is status upper nibble 0x8 with any velocity, or upper nibble 0x9 with velocity 0. A note-off for any other note has no effect.
- R10: A status byte (bit 7 = 1) received in the middle of a message restarts the message. Status bytes other than 0x8n and 0x9n, and data bytes that arrive outside a message, change nothing.
- R11: The low nibble of the status byte (the channel) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| midi_rx_i | input | 1 | Asynchronous serial MIDI line. Idles high |
| note_o | output | 7 | Number of the note currently sounding, 0 when none |
| note_vld_o | output | 1 | High while a note is shown on `note_o` |

## Verification
Assertions check the sampling rhythm on every cycle. The first sample must fall 191 counted cycles into a frame and each later sample 127 cycles after the one before. Every delivered byte must hold exactly eight samples, and the receiver may only re-arm after the line has been seen high. Further assertions check the outputs on every cycle. They may move only on a received byte, may rise only on a velocity byte, and must fall only to a zero note. Whether the values are right can be shown only by the bench's scenarios. These cover the decoded note under varied bit patterns, the bit-period tolerance, the gaps between frames, a matching against a non-matching note-off, a restart in mid-message, and a line held low after a frame.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;

  typedef enum logic [1:0] {
    SMP_REARM = 2'd0,
    SMP_IDLE  = 2'd1,
    SMP_DATA  = 2'd2
  } smp_state_e;

  typedef enum logic [1:0] {
    POS_NONE = 2'd0,
    POS_KEY  = 2'd1,
    POS_VEL  = 2'd2
  } msg_pos_e;

  typedef enum logic {
    EV_OFF = 1'b0,
    EV_ON  = 1'b1
  } ev_kind_e;

  localparam logic [3:0] NIB_NOTE_ON  = 4'h9;
  localparam logic [3:0] NIB_NOTE_OFF = 4'h8;

endpackage

// File: rtl/midi_line_sync.sv
module midi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int NST = (STAGES < 1) ? 1 : STAGES;

  logic [NST-1:0] stg_q;

  generate
    if (NST == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 1'b1;
        else        stg_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= {stg_q[NST-2:0], line_i};
      end
    end
  endgenerate

  assign line_o = stg_q[NST-1];

endmodule

// File: rtl/midi_bit_sampler.sv
module midi_bit_sampler
  import midi_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 128,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_vld_o
);

  localparam int FIRST_LOAD = CLKS_PER_BIT + CLKS_PER_BIT / 2 - 1;
  localparam int NEXT_LOAD  = CLKS_PER_BIT - 1;
  localparam int CNT_W      = $clog2(FIRST_LOAD + 1);
  localparam int IDX_W      = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int SCNT_W     = $clog2(DATA_BITS + 1);

  smp_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] shf_q, shf_d;
  logic [DATA_BITS-1:0] byte_q, byte_d;
  logic                 vld_q, vld_d;
  logic                 smp;
  logic                 shf_en;
  logic                 byte_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = {line_i, shf_q[DATA_BITS-1:1]};
    byte_d  = {line_i, shf_q[DATA_BITS-1:1]};
    vld_d   = 1'b0;
    smp     = 1'b0;
    shf_en  = 1'b0;
    byte_en = 1'b0;
    unique case (state_q)
      SMP_REARM: begin
        if (line_i) state_d = SMP_IDLE;
      end
      SMP_IDLE: begin
        if (!line_i) begin
          state_d = SMP_DATA;
          cnt_d   = CNT_W'(FIRST_LOAD);
          idx_d   = '0;
        end
      end
      SMP_DATA: begin
        if (cnt_q == '0) begin
          smp    = 1'b1;
          shf_en = 1'b1;
          cnt_d  = CNT_W'(NEXT_LOAD);
          if (idx_q == IDX_W'(DATA_BITS - 1)) begin
            state_d = SMP_REARM;
            byte_en = 1'b1;
            vld_d   = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = SMP_REARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SMP_REARM;
      cnt_q   <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q  <= '0;
      byte_q <= '0;
    end else begin
      if (shf_en)  shf_q  <= shf_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;

  // Checker state: cycles since the last sample, samples in this frame.
  logic [CNT_W-1:0]  gap_q;
  logic [SCNT_W-1:0] scnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      scnt_q <= '0;
    end else begin
      if (state_q != SMP_DATA || smp) gap_q <= '0;
      else                            gap_q <= gap_q + CNT_W'(1);
      if (state_q == SMP_IDLE) scnt_q <= '0;
      else if (smp)            scnt_q <= scnt_q + SCNT_W'(1);
    end
  end

  p_first_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && idx_q == '0) |-> (gap_q == CNT_W'(FIRST_LOAD)));

  p_bit_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && idx_q != '0) |-> (gap_q == CNT_W'(NEXT_LOAD)));

  p_eight_samples_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (scnt_q == SCNT_W'(DATA_BITS)));

  p_arm_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SMP_IDLE && $past(state_q) == SMP_REARM) |-> $past(line_i));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

endmodule

// File: rtl/midi_msg_tracker.sv
module midi_msg_tracker
  import midi_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NOTE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic [NOTE_W-1:0] note_o,
  output logic              note_vld_o
);

  localparam int NIB_LSB = BYTE_W - 4;

  msg_pos_e          pos_q, pos_d;
  ev_kind_e          kind_q, kind_d;
  logic [NOTE_W-1:0] key_q, key_d;
  logic [NOTE_W-1:0] note_q, note_d;
  logic              vld_q, vld_d;
  logic              is_status;
  logic [3:0]        nib;
  logic [NOTE_W-1:0] payload;

  assign is_status = byte_i[BYTE_W-1];
  assign nib       = byte_i[BYTE_W-1:NIB_LSB];
  assign payload   = byte_i[NOTE_W-1:0];

  always_comb begin
    pos_d  = pos_q;
    kind_d = kind_q;
    key_d  = key_q;
    note_d = note_q;
    vld_d  = vld_q;
    if (byte_vld_i) begin
      if (is_status) begin
        if (nib == NIB_NOTE_ON) begin
          pos_d  = POS_KEY;
          kind_d = EV_ON;
        end else if (nib == NIB_NOTE_OFF) begin
          pos_d  = POS_KEY;
          kind_d = EV_OFF;
        end else begin
          pos_d = POS_NONE;
        end
      end else begin
        unique case (pos_q)
          POS_KEY: begin
            key_d = payload;
            pos_d = POS_VEL;
          end
          POS_VEL: begin
            pos_d = POS_NONE;
            if (kind_q == EV_ON && payload != '0) begin
              note_d = key_q;
              vld_d  = 1'b1;
            end else if (vld_q && note_q == key_q) begin
              note_d = '0;
              vld_d  = 1'b0;
            end
          end
          default: pos_d = POS_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_NONE;
      kind_q <= EV_OFF;
      key_q  <= '0;
      note_q <= '0;
      vld_q  <= 1'b0;
    end else if (byte_vld_i) begin
      pos_q  <= pos_d;
      kind_q <= kind_d;
      key_q  <= key_d;
      note_q <= note_d;
      vld_q  <= vld_d;
    end
  end

  assign note_o     = note_q;
  assign note_vld_o = vld_q;

  p_hold_between_bytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |=> ($stable(note_o) && $stable(note_vld_o)));

  p_on_after_velocity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(note_vld_o) |-> ($past(pos_q) == POS_VEL));

  p_off_clears_note_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(note_vld_o) |-> (note_o == '0));

  p_status_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && byte_i[BYTE_W-1]) |=> (pos_q != POS_VEL));

endmodule

// File: rtl/midi_note_rx.sv
module midi_note_rx #(
  parameter int CLKS_PER_BIT = 128,
  parameter int SYNC_STAGES  = 2,
  parameter int NOTE_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              midi_rx_i,
  output logic [NOTE_W-1:0] note_o,
  output logic              note_vld_o
);

  localparam int BYTE_W = 8;

  logic [1:0]        rst_sq;
  logic              rst_sync_n;
  logic              line_s;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_byte_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sync_n = rst_sq[1];

  midi_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .line_i (midi_rx_i),
    .line_o (line_s)
  );

  midi_bit_sampler #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (BYTE_W)
  ) u_sampler (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_i     (line_s),
    .byte_o     (rx_byte),
    .byte_vld_o (rx_byte_vld)
  );

  midi_msg_tracker #(
    .BYTE_W(BYTE_W),
    .NOTE_W(NOTE_W)
  ) u_tracker (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .byte_i     (rx_byte),
    .byte_vld_i (rx_byte_vld),
    .note_o     (note_o),
    .note_vld_o (note_vld_o)
  );

endmodule

// File: tb/midi_note_rx_tb.sv
module midi_note_rx_tb;

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic [6:0] note;
  logic       note_vld;

  int   checks;
  int   errors;
  bit   done;

  logic [6:0] exp_note;
  bit         exp_vld;
  int         m_pos;
  bit         m_on;
  logic [6:0] m_key;

  midi_note_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .midi_rx_i  (rx),
    .note_o     (note),
    .note_vld_o (note_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference for the message layer, written from R7..R11.
  task automatic model_byte(input logic [7:0] b);
    if (b[7]) begin
      if (b[7:4] == 4'h9)      begin m_pos = 1; m_on = 1'b1; end
      else if (b[7:4] == 4'h8) begin m_pos = 1; m_on = 1'b0; end
      else                          m_pos = 0;
    end else if (m_pos == 1) begin
      m_key = b[6:0];
      m_pos = 2;
    end else if (m_pos == 2) begin
      m_pos = 0;
      if (m_on && b[6:0] != 7'd0) begin
        exp_note = m_key;
        exp_vld  = 1'b1;
      end else if (exp_vld && exp_note == m_key) begin
        exp_note = 7'd0;
        exp_vld  = 1'b0;
      end
    end
  endtask

  task automatic idle_bits(input int per, input int n);
    rx = 1'b1;
    repeat (per * n) @(negedge clk);
  endtask

  // stop_low_bits > 0 drives the stop bit low for that many bit times.
  task automatic send_byte(input logic [7:0] b, input int per, input int stop_low_bits);
    rx = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (per) @(negedge clk);
    end
    if (stop_low_bits > 0) begin
      rx = 1'b0;
      repeat (per * stop_low_bits) @(negedge clk);
    end
    rx = 1'b1;
    repeat (per) @(negedge clk);
    model_byte(b);
  endtask

  task automatic check_out(input string req);
    checks++;
    if (note !== exp_note || note_vld !== exp_vld) begin
      errors++;
      $display("FAIL %s: note=%02h vld=%0b expected note=%02h vld=%0b",
               req, note, note_vld, exp_note, exp_vld);
    end
  endtask

  task automatic send_msg(input logic [7:0] s, input logic [7:0] k, input logic [7:0] v,
                          input int per, input int gap);
    send_byte(s, per, 0);
    idle_bits(per, gap);
    send_byte(k, per, 0);
    idle_bits(per, gap);
    send_byte(v, per, 0);
    idle_bits(per, gap);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    exp_note = 7'd0;
    exp_vld  = 1'b0;
    m_pos    = 0;
    m_on     = 1'b0;
    m_key    = 7'd0;
    rx       = 1'b1;
    rst_n    = 1'b0;
    void'($urandom(32'h00C0FFEE));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    check_out("R1 reset state");

    // R7 R3 plain note-on at the nominal rate
    send_msg(8'h90, 8'h3C, 8'h64, 128, 1);
    check_out("R7 note-on shows note");

    // R8 outputs hold after status and note bytes; R11 channel 1
    send_byte(8'h91, 128, 0);
    check_out("R8 hold after status byte");
    send_byte(8'h45, 128, 0);
    check_out("R8 hold after note byte");
    send_byte(8'h20, 128, 0);
    check_out("R11 note-on on channel 1");

    // R9 non-matching note-off has no effect
    send_msg(8'h80, 8'h3C, 8'h40, 128, 0);
    check_out("R9 non-matching note-off ignored");

    // R9 R11 note-on with velocity 0 on channel 15 is a matching off
    send_msg(8'h9F, 8'h45, 8'h00, 128, 2);
    check_out("R9 velocity-0 note-off clears");

    // R10 restart mid-message
    send_byte(8'h90, 128, 0);
    send_byte(8'h22, 128, 0);
    send_msg(8'h90, 8'h33, 8'h7F, 128, 0);
    check_out("R10 status restarts message");

    // R10 stray data bytes and an unrelated status are ignored
    send_byte(8'h12, 128, 0);
    send_byte(8'h13, 128, 0);
    send_msg(8'hC0, 8'h05, 8'h07, 128, 0);
    check_out("R10 other status and stray data ignored");

    // R4 R3 back-to-back frames at the slow tolerance edge
    send_msg(8'h9A, 8'h7F, 8'h01, 129, 0);
    check_out("R4 back-to-back frames, period 129");

    // R3 fast tolerance edge, note number 0
    send_msg(8'h93, 8'h00, 8'h10, 127, 0);
    check_out("R3 period 127, note 0");

    // R3 alternating bit pattern
    send_msg(8'h95, 8'h55, 8'h2A, 128, 3);
    check_out("R3 alternating bits LSB first");

    // R5 R6 low stop bit on the note byte, line held low, then velocity
    send_byte(8'h90, 128, 0);
    send_byte(8'h11, 128, 4);
    send_byte(8'h40, 128, 0);
    check_out("R6 R5 low stop held, no extra byte");

    // R8 off for the shown note, then random traffic
    send_msg(8'h80, 8'h11, 8'h00, 128, 0);
    check_out("R9 note-off 0x8n clears");

    for (int n = 0; n < 14; n++) begin
      logic [7:0] st;
      logic [7:0] ky;
      logic [7:0] vl;
      int         per;
      int         gap;
      st  = {($urandom_range(0, 1) == 1) ? 4'h9 : 4'h8, 4'($urandom_range(0, 15))};
      if (exp_vld && $urandom_range(0, 2) == 0) ky = {1'b0, exp_note};
      else                                      ky = {1'b0, 7'($urandom_range(0, 127))};
      vl  = ($urandom_range(0, 3) == 0) ? 8'h00 : {1'b0, 7'($urandom_range(1, 127))};
      per = $urandom_range(127, 129);
      gap = $urandom_range(0, 2);
      send_msg(st, ky, vl, per, gap);
      check_out("R7 R9 R4 random message");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule